// File: doc/BRIEF.md
# PLL synthesizer serial loader

This block keeps a 28-bit clock-management word for a quad converter board and programs the board's two frequency synthesizers from it. One synthesizer clocks converter pair AB and the other clocks pair CD. Each synthesizer has a 12-bit setting made of a 9-bit multiplier M and a 3-bit divider code N. The N code selects a divide ratio: 000 gives 1, 001 gives 1.5, 010 gives 2, 011 gives 3, 100 gives 4, 101 gives 6, 110 gives 8 and 111 gives 12. Software writes the word first. A separate load command then sends both settings at the same time over two write-only serial links. Neither link can be read back.

The word also holds four clock-source bits. These drive two 2-bit selects that choose, for each converter, either the on-board synthesizer (0) or an external clock (1). After reset the selects point at the external clocks. Both synthesizers are held in master reset until the first load command is accepted.

Top module: `pll_cfg_loader`

## Requirements
- R1: After reset, `busy`, both serial clocks, both serial data lines and both load strobes are 0. Both source selects are 2'b11 (external). Both master resets are 1.
- R2: A register write updates the selects on the next clock. `ab_src_sel` = {word[25], word[24]} and `cd_src_sel` = {word[27], word[26]}. A write alone causes no serial clock activity.
- R3: A load command sends frame word[11:0] on the AB link and frame word[23:12] on the CD link. Each frame is 12 bits, MSB first, so the 3-bit N code (bits 11:9 or 23:21) goes out ahead of the 9-bit M value (bits 8:0 or 20:12).
- R4: The serial clock is the system clock divided by `SCLK_DIV`: low for the first half of each bit period and high for the second half. Data changes only while the serial clock is low, so it is stable at every rising edge.
- R5: After the 12th bit, the load strobe is high for exactly one serial period (`SCLK_DIV` clocks) with the serial clock low. `busy` is then cleared, so it stays high for 13×`SCLK_DIV` clocks per command.
- R6: A load command that arrives while `busy` is high is ignored. A register write during a transfer leaves the frame being sent unchanged, but it does update the selects.
- R7: The master resets stay high from reset until the first load command is accepted. They fall on the next clock and do not rise again until the next reset.
- R8: Both links run in lockstep: they share the same serial clock and load strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low global reset |
| reg_wr | input | 1 | Write strobe for the configuration word |
| reg_din | input | 28 | Configuration word payload |
| load_cmd | input | 1 | Start serial programming of both synthesizers |
| busy | output | 1 | High while frames or load strobes are being sent |
| ab_sclk | output | 1 | Serial clock, AB synthesizer |
| ab_sdata | output | 1 | Serial data, AB synthesizer |
| ab_load | output | 1 | Load strobe, AB synthesizer |
| ab_mrst | output | 1 | Master reset, AB synthesizer |
| cd_sclk | output | 1 | Serial clock, CD synthesizer |
| cd_sdata | output | 1 | Serial data, CD synthesizer |
| cd_load | output | 1 | Load strobe, CD synthesizer |
| cd_mrst | output | 1 | Master reset, CD synthesizer |
| ab_src_sel | output | 2 | Clock source for converters B,A (1 = external) |
| cd_src_sel | output | 2 | Clock source for converters D,C (1 = external) |

## Verification
The bench uses the default parameters: M_W=9, N_W=3 and SCLK_DIV=4. This gives 12-bit frames and a 52-clock transfer, so many commands fit in a short run. At this size the exact busy length, the four-clock load strobe and the rising-edge capture of each bit can all be counted cycle by cycle.

A shift-register monitor on each link rebuilds the frames and compares them with the queued expectations. It also catches a stray extra frame caused by a command issued mid-transfer, and a frame corrupted by a write made during shifting.

// File: rtl/pll_cfg_loader.sv
module pll_cfg_loader #(
  parameter int M_W      = 9,
  parameter int N_W      = 3,
  parameter int SCLK_DIV = 4,
  localparam int FW      = M_W + N_W,
  localparam int RW      = 2 * FW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_din,
  input  logic          load_cmd,
  output logic          busy,
  output logic          ab_sclk,
  output logic          ab_sdata,
  output logic          ab_load,
  output logic          ab_mrst,
  output logic          cd_sclk,
  output logic          cd_sdata,
  output logic          cd_load,
  output logic          cd_mrst,
  output logic [1:0]    ab_src_sel,
  output logic [1:0]    cd_src_sel
);
  localparam int PW = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int BW = $clog2(FW);
  localparam logic [PW-1:0] PH_LAST = PW'(SCLK_DIV - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(SCLK_DIV / 2);
  localparam logic [BW-1:0] BIT_LAST = BW'(FW - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LOAD} state_t;

  state_t        state;
  logic [RW-1:0] cfg_q;
  logic [FW-1:0] sr_ab, sr_cd;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitc;
  logic          mrst_q;
  logic          ph_end;

  assign ph_end = (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= {4'b1111, {(2*FW){1'b0}}};
    else if (reg_wr) cfg_q <= reg_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ph     <= '0;
      bitc   <= '0;
      sr_ab  <= '0;
      sr_cd  <= '0;
      mrst_q <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (load_cmd) begin
          state  <= S_SHIFT;
          ph     <= '0;
          bitc   <= '0;
          sr_ab  <= cfg_q[FW-1:0];
          sr_cd  <= cfg_q[2*FW-1:FW];
          mrst_q <= 1'b0;
        end
        S_SHIFT: begin
          ph <= ph_end ? '0 : ph + 1'b1;
          if (ph_end) begin
            if (bitc == BIT_LAST) state <= S_LOAD;
            else begin
              bitc  <= bitc + 1'b1;
              sr_ab <= {sr_ab[FW-2:0], 1'b0};
              sr_cd <= {sr_cd[FW-2:0], 1'b0};
            end
          end
        end
        S_LOAD: begin
          ph <= ph_end ? '0 : ph + 1'b1;
          if (ph_end) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign ab_sclk    = (state == S_SHIFT) && (ph >= PH_HIGH);
  assign cd_sclk    = ab_sclk;
  assign ab_sdata   = (state == S_SHIFT) && sr_ab[FW-1];
  assign cd_sdata   = (state == S_SHIFT) && sr_cd[FW-1];
  assign ab_load    = (state == S_LOAD);
  assign cd_load    = ab_load;
  assign ab_mrst    = mrst_q;
  assign cd_mrst    = mrst_q;
  assign ab_src_sel = cfg_q[2*FW+1:2*FW];
  assign cd_src_sel = cfg_q[2*FW+3:2*FW+2];
endmodule

// File: rtl/pll_cfg_loader_chk.sv
module pll_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       load_cmd,
  input logic       busy,
  input logic       ab_sclk,
  input logic       ab_sdata,
  input logic       ab_load,
  input logic       ab_mrst,
  input logic       cd_sclk,
  input logic       cd_sdata,
  input logic       cd_load,
  input logic [1:0] ab_src_sel,
  input logic [1:0] cd_src_sel
);
  AST_AB_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ab_sclk && $past(ab_sclk)) |-> $stable(ab_sdata)); // R4
  AST_CD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cd_sclk && $past(cd_sclk)) |-> $stable(cd_sdata)); // R4
  AST_LOAD_QUIET_CLK: assert property (@(posedge clk) disable iff (!rst_n) ab_load |-> (busy && !ab_sclk)); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!ab_sclk && !ab_load && !cd_sclk && !cd_load)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(reg_wr) |-> ($stable(ab_src_sel) && $stable(cd_src_sel))); // R2
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |-> (ab_sclk == cd_sclk && ab_load == cd_load)); // R8
  AST_MRST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ab_mrst) |-> $past(load_cmd)); // R7
  AST_MRST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) !$rose(ab_mrst)); // R7
endmodule

bind pll_cfg_loader pll_cfg_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .load_cmd(load_cmd), .busy(busy),
  .ab_sclk(ab_sclk), .ab_sdata(ab_sdata), .ab_load(ab_load), .ab_mrst(ab_mrst),
  .cd_sclk(cd_sclk), .cd_sdata(cd_sdata), .cd_load(cd_load),
  .ab_src_sel(ab_src_sel), .cd_src_sel(cd_src_sel)
);

// File: tb/pll_cfg_loader_tb_top.sv
module pll_cfg_loader_tb_top;
  localparam int FW  = 12;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [27:0] reg_din = '0;
  logic        load_cmd = 1'b0;
  logic        busy, ab_sclk, ab_sdata, ab_load, ab_mrst;
  logic        cd_sclk, cd_sdata, cd_load, cd_mrst;
  logic [1:0]  ab_src_sel, cd_src_sel;

  int total = 0, bad = 0;
  int sclk_edges = 0, frames_ab = 0, frames_cd = 0, pushes = 0;
  int ab_bits = 0, cd_bits = 0;
  logic [FW-1:0] ab_sh = '0, cd_sh = '0;
  logic [FW-1:0] q_ab[$], q_cd[$];
  bit done = 0;

  always #2 clk = ~clk;

  pll_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_din(reg_din), .load_cmd(load_cmd),
    .busy(busy), .ab_sclk(ab_sclk), .ab_sdata(ab_sdata), .ab_load(ab_load), .ab_mrst(ab_mrst),
    .cd_sclk(cd_sclk), .cd_sdata(cd_sdata), .cd_load(cd_load), .cd_mrst(cd_mrst),
    .ab_src_sel(ab_src_sel), .cd_src_sel(cd_src_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge ab_sclk) begin ab_sh = {ab_sh[FW-2:0], ab_sdata}; ab_bits++; sclk_edges++; end
  always @(posedge cd_sclk) begin cd_sh = {cd_sh[FW-2:0], cd_sdata}; cd_bits++; end

  always @(posedge ab_load) begin
    logic [FW-1:0] e;
    frames_ab++;
    if (q_ab.size() == 0) chk(0, "R6 unexpected AB frame", {20'd0, ab_sh}, 0);
    else begin
      e = q_ab.pop_front();
      chk(ab_sh == e, "R3 AB frame", {20'd0, ab_sh}, {20'd0, e});
    end
    chk(ab_bits == FW, "R4 AB bit count", ab_bits, FW);
    ab_bits = 0;
  end

  always @(posedge cd_load) begin
    logic [FW-1:0] e;
    frames_cd++;
    if (q_cd.size() == 0) chk(0, "R6 unexpected CD frame", {20'd0, cd_sh}, 0);
    else begin
      e = q_cd.pop_front();
      chk(cd_sh == e, "R3 CD frame", {20'd0, cd_sh}, {20'd0, e});
    end
    chk(cd_bits == FW, "R8 CD bit count", cd_bits, FW);
    cd_bits = 0;
  end

  always @(posedge ab_load) begin
    int w;
    w = 0;
    @(negedge clk);
    while (ab_load) begin
      chk(!ab_sclk, "R5 sclk low in load", ab_sclk, 0);
      w++;
      @(negedge clk);
    end
    chk(w == DIV, "R5 load width", w, DIV);
  end

  task automatic write_cfg(input logic [27:0] w);
    @(negedge clk); reg_wr = 1'b1; reg_din = w;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic start_load(input logic [27:0] w, input bit expect_frame);
    @(negedge clk); load_cmd = 1'b1;
    if (expect_frame) begin
      q_ab.push_back(w[11:0]);
      q_cd.push_back(w[23:12]);
      pushes++;
    end
    @(negedge clk); load_cmd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic full_load(input logic [27:0] w);
    int n;
    write_cfg(w);
    start_load(w, 1);
    chk(busy, "R5 busy after command", busy, 1);
    wait_idle(n);
    chk(n == 13 * DIV, "R5 busy length", n, 13 * DIV);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, e0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 busy", busy, 0);
    chk(!ab_sclk && !cd_sclk, "R1 sclk", {ab_sclk, cd_sclk}, 0);
    chk(!ab_sdata && !cd_sdata, "R1 sdata", {ab_sdata, cd_sdata}, 0);
    chk(!ab_load && !cd_load, "R1 load", {ab_load, cd_load}, 0);
    chk(ab_src_sel == 2'b11 && cd_src_sel == 2'b11, "R1 selects", {ab_src_sel, cd_src_sel}, 4'hF);
    chk(ab_mrst && cd_mrst, "R1 mrst", {ab_mrst, cd_mrst}, 2'b11);

    e0 = sclk_edges;
    @(negedge clk); reg_wr = 1'b1; reg_din = {4'b0110, 24'h5A3C21};
    @(negedge clk); reg_wr = 1'b0;
    chk(ab_src_sel == 2'b10, "R2 ab select", ab_src_sel, 2'b10);
    chk(cd_src_sel == 2'b01, "R2 cd select", cd_src_sel, 2'b01);
    repeat (20) @(negedge clk);
    chk(sclk_edges == e0 && !busy, "R2 write starts nothing", sclk_edges, e0);
    chk(ab_mrst && cd_mrst, "R7 mrst held before load", {ab_mrst, cd_mrst}, 2'b11);

    start_load({4'b0110, 24'h5A3C21}, 1);
    chk(!ab_mrst && !cd_mrst, "R7 mrst released", {ab_mrst, cd_mrst}, 0);
    wait_idle(n);
    chk(n == 13 * DIV, "R5 busy length first", n, 13 * DIV);
    repeat (3) @(negedge clk);

    full_load({4'b0000, 24'hFFFFFF});
    full_load({4'b1001, 24'hA5A5A5});
    full_load({4'b0011, 24'h000E00});
    full_load({4'b1100, 24'h1FF1FF});
    chk(!ab_mrst && !cd_mrst, "R7 mrst stays low", {ab_mrst, cd_mrst}, 0);

    write_cfg({4'b0000, 24'h123456});
    start_load({4'b0000, 24'h123456}, 1);
    repeat (10) @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_din = {4'b1010, 24'hFEDCBA};
    @(negedge clk); reg_wr = 1'b0;
    chk(ab_src_sel == 2'b10 && cd_src_sel == 2'b10, "R6 write during busy updates selects", {ab_src_sel, cd_src_sel}, 4'hA);
    @(negedge clk); load_cmd = 1'b1;
    @(negedge clk); load_cmd = 1'b0;
    wait_idle(n);
    repeat (3 * 13 * DIV) @(negedge clk);
    chk(!busy, "R6 ignored command leaves idle", busy, 0);
    chk(frames_ab == pushes && q_ab.size() == 0, "R6 AB frame count", frames_ab, pushes);
    chk(frames_cd == pushes && q_cd.size() == 0, "R6 CD frame count", frames_cd, pushes);

    start_load({4'b1010, 24'hFEDCBA}, 1);
    wait_idle(n);
    chk(n == 13 * DIV, "R5 busy length after ignore", n, 13 * DIV);
    repeat (3) @(negedge clk);
    chk(frames_ab == pushes && frames_cd == pushes, "R8 both links framed", frames_ab, pushes);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule